// File: doc/BRIEF.md
# Display Controller I/O Register Front End

This block sits on the byte-wide I/O port bus of a display controller and answers accesses to the port window from 0x3B0 to 0x3DF. It keeps the miscellaneous output register, whose bit 0 selects between mono and colour addressing. In mono mode, the 0x3Bx and 0x3Dx port groups swap places, so the CRTC index and data ports can be reached at 0x3B4/0x3B5 instead of 0x3D4/0x3D5. It holds the CRTC index and a 64-entry CRTC register file. That file has a write-protect bit that locks the low timing registers.

A bank register turns a single byte written by software into two frame-buffer window base addresses, one for reads and one for writes. The segment granularity is either 64 KB or 128 KB. An override bit in the CRTC file, or an external lock from the graphics controller, freezes both bases. Any CRTC write that really changes a timing-relevant register raises a one-cycle pulse, so the downstream timing logic can recompute. The sequencer, graphics controller and pixel paths are outside this block.

Top module: `vga_xreg_decoder`

## Requirements
- R1: After a synchronous reset, the miscellaneous register reads 0x01, the bank register and both bank bases are 0, the CRTC index and every CRTC register are 0, the read data is 0xFF and the timing pulse is low.
- R2: While miscellaneous bit 0 is 0, the address of every access to 0x3B0–0x3BF or 0x3D0–0x3DF is XORed with 0x60 before decoding. The CRTC is then reached at 0x3B4/0x3B5, and 0x3D4/0x3D5 act as unimplemented ports. While bit 0 is 1, no translation is applied.
- R3: A write to port 0x3C2 loads the miscellaneous register, and a read of port 0x3CC returns it. Neither port is translated.
- R4: Port 0x3CD holds the bank register, and a read returns exactly the last byte written there.
- R5: On a bank register write, bits 2:0 give the write bank, bits 5:3 give the read bank, and bits 7:6 give the mode. Mode 0 sets each base to bank×2^17, mode 1 sets it to bank×2^16, and modes 2 and 3 leave both bases unchanged. Each base is 20 bits wide.
- R6: When CRTC register 0x23 bit 7 or the gfx_bank_lock input is 1, a bank register write still updates the bank register but leaves both bases unchanged.
- R7: A write to the CRTC index port stores bits 5:0 of the data. A read of the index port returns the index, and a read of the data port returns the indexed CRTC register.
- R8: While CRTC register 0x11 bit 7 is 1, writes to CRTC registers 0–6 are discarded, and a write to register 7 changes only its bit 4.
- R9: timing_pulse is high for exactly the cycle after an accepted CRTC data write that changes the stored value at an index outside 0x0E–0x10. It stays low in every other case.
- R10: A read presents its data on bus_rdata in the cycle after bus_rd, and the data holds until the next read. Reads of any port other than 0x3CC, 0x3CD and the two CRTC ports return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| gfx_bank_lock | input | 1 | Graphics-controller lock that freezes the bank bases |
| bus_rdata | output | 8 | Registered read data |
| rd_bank_base | output | 20 | Base address of the read window |
| wr_bank_base | output | 20 | Base address of the write window |
| timing_pulse | output | 1 | One-cycle request to recompute display timing |

## Verification
The bench switches between mono and colour addressing. It checks that only the translated CRTC ports respond: a decoder that swapped the wrong group, or ignored bit 0, would return 0xFF from the live port and register data from the dead one. The bench walks the bank register through all four modes and both override sources. A wrong shift or swapped fields would show up as a misplaced base, and an override that also blocked the register itself would break readback. The bench writes protected registers 0–6 and register 7 with the lock set, writes unchanged values, and writes to indices 0x0E–0x10. A design that leaked protected bits, pulsed on no change, or pulsed in the quiet range would differ from the model in that cycle.

// File: rtl/vxd_pkg.sv
package vxd_pkg;

  // Ports after mono/colour translation
  localparam logic [15:0] PORT_MISC_WR = 16'h03C2;
  localparam logic [15:0] PORT_MISC_RD = 16'h03CC;
  localparam logic [15:0] PORT_BANK    = 16'h03CD;
  localparam logic [15:0] PORT_CIDX    = 16'h03D4;
  localparam logic [15:0] PORT_CDAT    = 16'h03D5;
  localparam logic [15:0] GRP_MONO     = 16'h03B0;
  localparam logic [15:0] GRP_COLR     = 16'h03D0;
  localparam logic [15:0] ALIAS_FLIP   = 16'h0060;

  // CRTC register numbers with side effects
  localparam logic [7:0] CREG_OVFL    = 8'h07;
  localparam logic [7:0] CREG_QUIET_LO = 8'h0E;
  localparam logic [7:0] CREG_QUIET_HI = 8'h10;
  localparam logic [7:0] CREG_PROT    = 8'h11;
  localparam logic [7:0] CREG_BANKOVR = 8'h23;
  localparam int         PROT_BIT     = 7;
  localparam int         BANKOVR_BIT  = 7;
  localparam logic [7:0] OVFL_OPEN_MASK = 8'h10;

  typedef enum logic [1:0] {
    SEG_LARGE = 2'd0,
    SEG_SMALL = 2'd1,
    SEG_KEEP2 = 2'd2,
    SEG_KEEP3 = 2'd3
  } seg_mode_e;

  typedef struct packed {
    logic misc_wr;
    logic misc_rd;
    logic bank;
    logic cidx;
    logic cdat;
  } port_sel_t;

endpackage

// File: rtl/vxd_port_decode.sv
module vxd_port_decode
  import vxd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mono,
  output port_sel_t         sel
);

  logic              in_alias_grp;
  logic [ADDR_W-1:0] grp;
  logic [ADDR_W-1:0] eff;

  always_comb begin
    grp          = {addr[ADDR_W-1:4], 4'h0};
    in_alias_grp = (grp == ADDR_W'(GRP_MONO)) || (grp == ADDR_W'(GRP_COLR));
    eff          = (in_alias_grp && mono) ? (addr ^ ADDR_W'(ALIAS_FLIP)) : addr;
    sel.misc_wr  = (eff == ADDR_W'(PORT_MISC_WR));
    sel.misc_rd  = (eff == ADDR_W'(PORT_MISC_RD));
    sel.bank     = (eff == ADDR_W'(PORT_BANK));
    sel.cidx     = (eff == ADDR_W'(PORT_CIDX));
    sel.cdat     = (eff == ADDR_W'(PORT_CDAT));
  end

endmodule

// File: rtl/vxd_crtc_file.sv
module vxd_crtc_file
  import vxd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] cur_q,
  output logic              prot,
  output logic              bank_ovr,
  output logic              tpulse
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [DATA_W-1:0] nxt_val;
  logic              low_locked;
  logic              is_ovfl;
  logic              accept;
  logic              quiet;
  logic              changed;

  always_comb begin
    cur_q      = regs[idx_q];
    prot       = regs[IDX_W'(CREG_PROT)][PROT_BIT];
    bank_ovr   = regs[IDX_W'(CREG_BANKOVR)][BANKOVR_BIT];
    low_locked = prot && (idx_q < IDX_W'(CREG_OVFL));
    is_ovfl    = (idx_q == IDX_W'(CREG_OVFL));
    if (prot && is_ovfl)
      nxt_val = (cur_q & ~DATA_W'(OVFL_OPEN_MASK)) | (wdata & DATA_W'(OVFL_OPEN_MASK));
    else
      nxt_val = wdata;
    accept  = dat_we && !low_locked;
    quiet   = (idx_q >= IDX_W'(CREG_QUIET_LO)) && (idx_q <= IDX_W'(CREG_QUIET_HI));
    changed = (nxt_val != cur_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      tpulse <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      tpulse <= accept && changed && !quiet;
      if (accept) regs[idx_q] <= nxt_val;
      if (idx_we) idx_q <= wdata[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/vxd_bank_map.sv
module vxd_bank_map
  import vxd_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int BASE_W      = 20,
  parameter int SHIFT_LARGE = 17,
  parameter int SHIFT_SMALL = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [7:0]        wdata,
  input  logic              hold,
  output logic [7:0]        bank_q,
  output logic [BASE_W-1:0] wr_base,
  output logic [BASE_W-1:0] rd_base
);

  localparam int NFIELD = 2;  // field 0 = write bank, field 1 = read bank

  seg_mode_e         mode;
  logic [BASE_W-1:0] base_q [NFIELD];

  assign mode = seg_mode_e'(wdata[7:6]);

  always_ff @(posedge clk) begin
    if (rst) bank_q <= '0;
    else if (we) bank_q <= wdata;
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    logic [SEL_W-1:0] fsel;
    assign fsel = wdata[(f+1)*SEL_W-1 : f*SEL_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[f] <= '0;
      end else if (we && !hold) begin
        case (mode)
          SEG_LARGE: base_q[f] <= BASE_W'(fsel) << SHIFT_LARGE;
          SEG_SMALL: base_q[f] <= BASE_W'(fsel) << SHIFT_SMALL;
          default:   base_q[f] <= base_q[f];
        endcase
      end
    end
  end

  assign wr_base = base_q[0];
  assign rd_base = base_q[1];

endmodule

// File: rtl/vga_xreg_decoder.sv
module vga_xreg_decoder
  import vxd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CRTC_IDX_W  = 6,
  parameter int BANK_SEL_W  = 3,
  parameter int BASE_W      = 20,
  parameter int SHIFT_LARGE = 17,
  parameter int SHIFT_SMALL = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              gfx_bank_lock,
  output logic [7:0]        bus_rdata,
  output logic [BASE_W-1:0] rd_bank_base,
  output logic [BASE_W-1:0] wr_bank_base,
  output logic              timing_pulse
);

  localparam logic [7:0] MISC_RESET = 8'h01;
  localparam logic [7:0] OPEN_BUS   = 8'hFF;

  port_sel_t             sel;
  logic [7:0]            misc_q;
  logic [7:0]            bank_q;
  logic [CRTC_IDX_W-1:0] crtc_idx;
  logic [7:0]            crtc_cur;
  logic                  crtc_prot;
  logic                  crtc_bank_ovr;
  logic                  bank_we;
  logic                  bank_hold;
  logic                  crtc_idx_we;
  logic                  crtc_dat_we;
  logic [7:0]            rd_mux;

  vxd_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .mono (~misc_q[0]),
    .sel  (sel)
  );

  assign bank_we     = bus_wr && sel.bank;
  assign crtc_idx_we = bus_wr && sel.cidx;
  assign crtc_dat_we = bus_wr && sel.cdat;
  assign bank_hold   = crtc_bank_ovr || gfx_bank_lock;

  vxd_crtc_file #(.IDX_W(CRTC_IDX_W), .DATA_W(8)) u_crtc (
    .clk      (clk),
    .rst      (rst),
    .idx_we   (crtc_idx_we),
    .dat_we   (crtc_dat_we),
    .wdata    (bus_wdata),
    .idx_q    (crtc_idx),
    .cur_q    (crtc_cur),
    .prot     (crtc_prot),
    .bank_ovr (crtc_bank_ovr),
    .tpulse   (timing_pulse)
  );

  vxd_bank_map #(
    .SEL_W(BANK_SEL_W), .BASE_W(BASE_W),
    .SHIFT_LARGE(SHIFT_LARGE), .SHIFT_SMALL(SHIFT_SMALL)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (bank_we),
    .wdata   (bus_wdata),
    .hold    (bank_hold),
    .bank_q  (bank_q),
    .wr_base (wr_bank_base),
    .rd_base (rd_bank_base)
  );

  always_ff @(posedge clk) begin
    if (rst) misc_q <= MISC_RESET;
    else if (bus_wr && sel.misc_wr) misc_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = OPEN_BUS;
    if (sel.misc_rd)   rd_mux = misc_q;
    else if (sel.bank) rd_mux = bank_q;
    else if (sel.cidx) rd_mux = 8'(crtc_idx);
    else if (sel.cdat) rd_mux = crtc_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= OPEN_BUS;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/vxd_chk.sv
module vxd_chk #(
  parameter int IDX_W  = 6,
  parameter int BASE_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              bank_we,
  input logic              bank_hold,
  input logic              crtc_idx_we,
  input logic              crtc_dat_we,
  input logic              crtc_prot,
  input logic [IDX_W-1:0]  crtc_idx,
  input logic [BASE_W-1:0] rd_bank_base,
  input logic [BASE_W-1:0] wr_bank_base,
  input logic              timing_pulse
);

  // R9
  pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
    timing_pulse |-> $past(crtc_dat_we));

  // R8
  locked_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (crtc_dat_we && crtc_prot && (crtc_idx < IDX_W'(7))) |=> !timing_pulse);

  // R5
  base_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> ($stable(rd_bank_base) && $stable(wr_bank_base)));

  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_we && bank_hold) |=> ($stable(rd_bank_base) && $stable(wr_bank_base)));

  // R7
  index_mask_chk: assert property (@(posedge clk) disable iff (rst)
    crtc_idx_we |=> (crtc_idx == $past(bus_wdata[IDX_W-1:0])));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind vga_xreg_decoder vxd_chk #(.IDX_W(CRTC_IDX_W), .BASE_W(BASE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bank_we      (bank_we),
  .bank_hold    (bank_hold),
  .crtc_idx_we  (crtc_idx_we),
  .crtc_dat_we  (crtc_dat_we),
  .crtc_prot    (crtc_prot),
  .crtc_idx     (crtc_idx),
  .rd_bank_base (rd_bank_base),
  .wr_bank_base (wr_bank_base),
  .timing_pulse (timing_pulse)
);

// File: tb/vga_xreg_decoder_test.sv
`timescale 1ns/1ps
module vga_xreg_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        gfx_bank_lock = 1'b0;
  logic [7:0]  bus_rdata;
  logic [19:0] rd_bank_base;
  logic [19:0] wr_bank_base;
  logic        timing_pulse;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  vga_xreg_decoder uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .gfx_bank_lock(gfx_bank_lock), .bus_rdata(bus_rdata),
    .rd_bank_base(rd_bank_base), .wr_bank_base(wr_bank_base), .timing_pulse(timing_pulse)
  );

  // ---------------- reference model ----------------
  int m_misc, m_bank, m_rdb, m_wrb, m_idx, m_rdata, m_pulse;
  int m_crtc [64];

  function automatic int xlate(int a);
    int hi = a >> 4;
    if ((hi == 'h3B || hi == 'h3D) && (m_misc & 1) == 0) return a ^ 'h60;
    return a;
  endfunction

  always @(posedge clk) begin
    int e, wd, mode, v, np;
    if (rst) begin
      m_misc = 1; m_bank = 0; m_rdb = 0; m_wrb = 0; m_idx = 0;
      m_rdata = 'hFF; m_pulse = 0;
      foreach (m_crtc[i]) m_crtc[i] = 0;
    end else begin
      e  = xlate(int'(bus_addr));
      wd = int'(bus_wdata);
      np = 0;
      if (bus_rd) begin
        if (e == 'h3CC)      m_rdata = m_misc;
        else if (e == 'h3CD) m_rdata = m_bank;
        else if (e == 'h3D4) m_rdata = m_idx;
        else if (e == 'h3D5) m_rdata = m_crtc[m_idx];
        else                 m_rdata = 'hFF;
      end
      if (bus_wr) begin
        if (e == 'h3C2) m_misc = wd;
        else if (e == 'h3CD) begin
          m_bank = wd;
          if ((m_crtc['h23] & 'h80) == 0 && !gfx_bank_lock) begin
            mode = wd >> 6;
            if (mode == 0) begin
              m_wrb = (wd & 7) * 131072; m_rdb = ((wd >> 3) & 7) * 131072;
            end else if (mode == 1) begin
              m_wrb = (wd & 7) * 65536;  m_rdb = ((wd >> 3) & 7) * 65536;
            end
          end
        end else if (e == 'h3D4) m_idx = wd & 63;
        else if (e == 'h3D5) begin
          if (!((m_crtc['h11] & 'h80) != 0 && m_idx < 7)) begin
            if ((m_crtc['h11] & 'h80) != 0 && m_idx == 7) v = (m_crtc[7] & 'hEF) | (wd & 'h10);
            else v = wd;
            if (v != m_crtc[m_idx] && (m_idx < 'h0E || m_idx > 'h10)) np = 1;
            m_crtc[m_idx] = v;
          end
        end
      end
      m_pulse = np;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " rdata"}, int'(bus_rdata), m_rdata);
      chk({cur_req, " rd_base"}, int'(rd_bank_base), m_rdb);
      chk({cur_req, " wr_base"}, int'(wr_bank_base), m_wrb);
      chk({cur_req, " pulse"}, int'(timing_pulse), m_pulse);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    bus_addr = 16'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    bus_addr = 16'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 rdata", int'(bus_rdata), 'hFF);
    chk("R1 bases", int'(rd_bank_base | wr_bank_base), 0);
    chk("R1 pulse", int'(timing_pulse), 0);
    rd('h3CC); chk("R1 misc", int'(bus_rdata), 1);
    rd('h3D5); chk("R1 crtc0", int'(bus_rdata), 0);

    cur_req = "R7";
    wr('h3D4, 'hC5); rd('h3D4); chk("R7 index", int'(bus_rdata), 'h05);
    cur_req = "R9";
    wr('h3D5, 'hAA); chk("R9 change pulse", int'(timing_pulse), 1);
    @(negedge clk);  chk("R9 one cycle", int'(timing_pulse), 0);
    wr('h3D5, 'hAA); chk("R9 same value", int'(timing_pulse), 0);
    cur_req = "R7";
    rd('h3D5); chk("R7 data", int'(bus_rdata), 'hAA);
    cur_req = "R2";
    rd('h3B4); chk("R2 mono port dead", int'(bus_rdata), 'hFF);

    cur_req = "R9";
    for (int q = 'h0D; q <= 'h11; q++) begin
      wr('h3D4, q); wr('h3D5, 'h40);
      chk("R9 quiet range", int'(timing_pulse), (q >= 'h0E && q <= 'h10) ? 0 : 1);
    end
    cur_req = "R8";
    wr('h3D4, 'h11); wr('h3D5, 'h80);
    wr('h3D4, 'h03); wr('h3D5, 'h55);
    chk("R8 locked no pulse", int'(timing_pulse), 0);
    rd('h3D5); chk("R8 locked reg3", int'(bus_rdata), 0);
    wr('h3D4, 'h07); wr('h3D5, 'hFF);
    rd('h3D5); chk("R8 reg7 bit4", int'(bus_rdata), 'h10);
    wr('h3D4, 'h11); wr('h3D5, 'h00);
    wr('h3D4, 'h03); wr('h3D5, 'h55);
    rd('h3D5); chk("R8 unlocked reg3", int'(bus_rdata), 'h55);

    cur_req = "R5";
    wr('h3CD, 'h2B);
    chk("R5 128K wr", int'(wr_bank_base), 'h60000);
    chk("R5 128K rd", int'(rd_bank_base), 'hA0000);
    wr('h3CD, 'h6B);
    chk("R5 64K wr", int'(wr_bank_base), 'h30000);
    chk("R5 64K rd", int'(rd_bank_base), 'h50000);
    wr('h3CD, 'h80); chk("R5 mode2 keep", int'(rd_bank_base), 'h50000);
    wr('h3CD, 'hFF); chk("R5 mode3 keep", int'(wr_bank_base), 'h30000);
    cur_req = "R4";
    rd('h3CD); chk("R4 readback", int'(bus_rdata), 'hFF);
    cur_req = "R6";
    gfx_bank_lock = 1'b1;
    wr('h3CD, 'h07); chk("R6 lock keep", int'(wr_bank_base), 'h30000);
    rd('h3CD); chk("R6 reg still written", int'(bus_rdata), 'h07);
    gfx_bank_lock = 1'b0;
    wr('h3D4, 'h23); wr('h3D5, 'h80);
    wr('h3CD, 'h3F); chk("R6 crtc override", int'(rd_bank_base), 'h50000);
    wr('h3D5, 'h00);
    wr('h3CD, 'h3F);
    chk("R6 released wr", int'(wr_bank_base), 'hE0000);
    chk("R6 released rd", int'(rd_bank_base), 'hE0000);

    cur_req = "R3";
    wr('h3C2, 'h00); rd('h3CC); chk("R3 misc", int'(bus_rdata), 0);
    cur_req = "R2";
    rd('h3B4); chk("R2 mono index", int'(bus_rdata), 'h23);
    rd('h3D4); chk("R2 colour dead", int'(bus_rdata), 'hFF);
    wr('h3B4, 'h03); wr('h3B5, 'h77);
    wr('h3D5, 'h11);
    rd('h3B5); chk("R2 mono data", int'(bus_rdata), 'h77);
    rd('h3CD); chk("R2 bank not moved", int'(bus_rdata), 'h3F);
    cur_req = "R10";
    rd('h3C0); chk("R10 unimpl", int'(bus_rdata), 'hFF);
    rd('h02F8); chk("R10 outside", int'(bus_rdata), 'hFF);
    wr('h3C2, 'h01);
    repeat (3) @(negedge clk);
    chk("R10 hold", int'(bus_rdata), 'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule